// File: doc/BRIEF.md
# Embedded Program/Erase Busy Status Generator

This block is the device-side engine that runs an embedded byte program, sector erase or whole-array erase, and it reports progress on the read path while the operation runs. The command decoder hands it one request: an operation code, a target address, a data byte and the current per-sector lock mask. The block stands in for the self-timed internal timer with a busy counter whose length is set by parameters: one length for a program and one for an erase. When the count runs out, the block commits the array update through a write port to an external byte array.

Reads go through the block. When it is idle, a read access captures the array byte at the read address. While an operation is in flight, a read access returns a polling status byte instead. Bit 7 is the inverse of the programmed bit 7, or 0 during an erase. Bit 6 flips on every read access. Software polls either bit to find out when the operation has finished. A busy output marks the whole operation. A synchronous reset abandons an operation that is still in progress.

Top module: `pe_status_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block leaves that edge idle: `busy`=0, `arr_we`=0, `data_out`=0x00, and the bit-6 toggle is cleared.
- R2: A read access is a clock edge at which `rd_strobe` is 1 and was 0 at the previous edge. When the block is not busy, `data_out` takes the array byte at `rd_addr` at that edge. `data_out` holds its value at every other edge, including while `rd_strobe` stays high.
- R3: A request is accepted when `req`=1 at an edge while the block is idle and `req_op` is not 2'b00. `busy` rises after that edge. For a byte program (`req_op`=2'b01), `busy` stays high for exactly PROG_CYCLES+1 cycles.
- R4: For a sector erase (`req_op`=2'b10), `busy` stays high for ERASE_CYCLES plus the sector size in bytes. For a full-array erase (`req_op`=2'b11), it stays high for ERASE_CYCLES plus the array depth.
- R5: A byte program writes the old byte ANDed with `req_data` at `req_addr`. Bits can only be cleared.
- R6: The sector number is the top SECT_W bits of an address. A sector erase sets every byte of the sector that holds `req_addr` to 0xFF and leaves all other bytes unchanged.
- R7: A full-array erase sets every byte of every unlocked sector to 0xFF and leaves the bytes of locked sectors unchanged.
- R8: A program or sector erase aimed at a sector whose bit in `sector_lock` (captured at acceptance) is 1 writes nothing. It still keeps `busy` high for its full duration.
- R9: A read access while busy returns a status byte. Bit 7 is the inverse of bit 7 of the program data, or 0 for either erase. Bits 5:0 are zero.
- R10: Bit 6 of the status byte is 0 on the first read access of each operation and inverts after each later read access during that operation.
- R11: A request with `req_op`=2'b00, or any request made while busy, is ignored. It does not restart the timer, change the array or raise `busy`.
- R12: Reset during the busy count abandons the operation, and no array byte is written.
- R13: `arr_we` is asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Operation request strobe |
| req_op | input | 2 | 01 program, 10 sector erase, 11 full erase, 00 none |
| req_addr | input | ADDR_W | Target byte (program) or any byte of target sector |
| req_data | input | 8 | Program data |
| sector_lock | input | 2**SECT_W | Per-sector write lock, 1 = locked |
| rd_strobe | input | 1 | Read strobe; rising edge is one read access |
| rd_addr | input | ADDR_W | Read address |
| arr_rd_addr | output | ADDR_W | Array read address |
| arr_rd_data | input | 8 | Array read data, combinational from `arr_rd_addr` |
| arr_we | output | 1 | Array write enable |
| arr_wr_addr | output | ADDR_W | Array write address |
| arr_wr_data | output | 8 | Array write data |
| busy | output | 1 | Operation in progress |
| data_out | output | 8 | Captured read data or status byte |

## Verification
The bench reads the whole array back after every operation. An erase walker that runs past the end of its sector, starts at the wrong base, or ignores the lock mask therefore shows up as a wrong byte somewhere in the sweep. The bench reads repeatedly while busy. A design that does not clear the toggle at each new operation would return bit 6 = 1 on a first read. A design that counts a held strobe as several reads would flip bit 6 too often. Busy cycles are counted exactly. An off-by-one timer, or a design that restarts when a second request arrives while busy, shows a wrong length. Resetting mid-count checks that an abandoned erase leaves its sector untouched. Programming over nonzero data checks that bits are ANDed rather than overwritten.

// File: rtl/pe_stat_pkg.sv
// Shared encodings for the program/erase status generator.
package pe_stat_pkg;
    // Operation request code; the value is part of the block's interface.
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_SECT = 2'b10,
        OP_CHIP = 2'b11
    } op_e;

    // Control sequencer state.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_WAIT   = 2'b01,
        ST_COMMIT = 2'b10
    } st_e;
endpackage

// File: rtl/pe_busy_timer.sv
// Busy-period down counter standing in for the self-timed operation clock.
// Assumes: load and run are never both high; load_val >= 1.
// expired goes high in the last counted cycle while run is high.
module pe_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on acceptance, count down while running, park at one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q > CNT_W'(1))) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = run && (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/pe_array_walker.sv
// Captures the accepted request and generates the array writes of the commit phase.
// A program is one read-modify-write (old AND new); an erase walks a sector or the
// whole array writing 0xFF, skipping sectors locked at acceptance.
// Assumes: cur_byte is the array byte at ptr in the same cycle.
module pe_array_walker
    import pe_stat_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SECT_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture,
    input  op_e                      op_in,
    input  logic [ADDR_W-1:0]        addr_in,
    input  logic [7:0]               data_in,
    input  logic [(1<<SECT_W)-1:0]   lock_in,
    input  logic                     active,
    input  logic [7:0]               cur_byte,
    output logic [ADDR_W-1:0]        ptr,
    output logic                     wr_en,
    output logic [7:0]               wr_data,
    output logic                     last,
    output logic                     poll_bit
);
    localparam int NSECT = 1 << SECT_W;
    localparam int OFF_W = ADDR_W - SECT_W;

    op_e               op_q;
    logic [7:0]        data_q;
    logic [NSECT-1:0]  lock_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [NSECT-1:0]  sect_hit;

    // Latch request fields and set the starting address of the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            data_q <= '0;
            lock_q <= '0;
            ptr_q  <= '0;
        end else if (capture) begin
            op_q   <= op_in;
            data_q <= data_in;
            lock_q <= lock_in;
            case (op_in)
                OP_PROG: ptr_q <= addr_in;
                OP_SECT: ptr_q <= {addr_in[ADDR_W-1 -: SECT_W], {OFF_W{1'b0}}};
                default: ptr_q <= '0;
            endcase
        end else if (active) begin
            ptr_q <= ptr_q + ADDR_W'(1);
        end
    end

    // One-hot decode of the sector under the pointer.
    for (genvar s = 0; s < NSECT; s++) begin : g_sect_hit
        assign sect_hit[s] = (ptr_q[ADDR_W-1 -: SECT_W] == SECT_W'(s));
    end

    // Write strobe, data and end-of-walk detection.
    always_comb begin
        wr_en   = active && ((sect_hit & lock_q) == '0);
        wr_data = (op_q == OP_PROG) ? (cur_byte & data_q) : 8'hFF;
        case (op_q)
            OP_SECT: last = &ptr_q[OFF_W-1:0];
            OP_CHIP: last = &ptr_q;
            default: last = 1'b1;
        endcase
        poll_bit = (op_q == OP_PROG) ? ~data_q[7] : 1'b0;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/pe_poll_status.sv
// Read-side output register: array data when idle, polling status when busy.
// Assumes: start pulses in the cycle an operation is accepted.
// Bit 6 returns the current toggle state, then the toggle inverts.
module pe_poll_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       busy,
    input  logic       rd_strobe,
    input  logic       poll_bit,
    input  logic [7:0] arr_byte,
    output logic [7:0] data_out
);
    logic rd_prev_q;
    logic toggle_q;
    logic [7:0] out_q;
    logic rd_edge;

    assign rd_edge = rd_strobe && !rd_prev_q;

    // Remember the strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev_q <= 1'b0;
        else        rd_prev_q <= rd_strobe;
    end

    // Toggle bit: cleared at each start, inverted by each busy read access.
    always_ff @(posedge clk) begin
        if (!rst_n)                toggle_q <= 1'b0;
        else if (start)            toggle_q <= 1'b0;
        else if (busy && rd_edge)  toggle_q <= ~toggle_q;
    end

    // Capture the read result on each read access only.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= '0;
        else if (rd_edge) out_q <= busy ? {poll_bit, toggle_q, 6'b0} : arr_byte;
    end

    assign data_out = out_q;
endmodule

// File: rtl/pe_status_gen.sv
// Top: accepts one program/erase request, counts its busy period, commits the
// array update, and substitutes polling status on reads while busy.
// Assumes: arr_rd_data is a combinational read of arr_rd_addr; PROG_CYCLES and
// ERASE_CYCLES are at least 1.
module pe_status_gen
    import pe_stat_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int SECT_W       = 2,
    parameter int PROG_CYCLES  = 3000,
    parameter int ERASE_CYCLES = 200000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic [1:0]             req_op,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [7:0]             req_data,
    input  logic [(1<<SECT_W)-1:0] sector_lock,
    input  logic                   rd_strobe,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [ADDR_W-1:0]      arr_rd_addr,
    input  logic [7:0]             arr_rd_data,
    output logic                   arr_we,
    output logic [ADDR_W-1:0]      arr_wr_addr,
    output logic [7:0]             arr_wr_data,
    output logic                   busy,
    output logic [7:0]             data_out
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    st_e               state_q, state_d;
    op_e               op_in;
    logic              accept;
    logic              expired;
    logic              walk_last;
    logic              poll_bit;
    logic [ADDR_W-1:0] walk_ptr;
    logic [CNT_W-1:0]  load_val;

    assign op_in    = op_e'(req_op);
    assign accept   = (state_q == ST_IDLE) && req && (op_in != OP_NONE);
    assign load_val = (op_in == OP_PROG) ? CNT_W'(PROG_CYCLES) : CNT_W'(ERASE_CYCLES);

    // Sequencer next state: idle -> count -> commit -> idle.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (accept)    state_d = ST_WAIT;
            ST_WAIT:   if (expired)   state_d = ST_COMMIT;
            ST_COMMIT: if (walk_last) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Sequencer state register; reset abandons any operation.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign busy        = (state_q != ST_IDLE);
    assign arr_rd_addr = (state_q == ST_COMMIT) ? walk_ptr : rd_addr;
    assign arr_wr_addr = walk_ptr;

    pe_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (load_val),
        .run      (state_q == ST_WAIT),
        .expired  (expired)
    );

    pe_array_walker #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (accept),
        .op_in    (op_in),
        .addr_in  (req_addr),
        .data_in  (req_data),
        .lock_in  (sector_lock),
        .active   (state_q == ST_COMMIT),
        .cur_byte (arr_rd_data),
        .ptr      (walk_ptr),
        .wr_en    (arr_we),
        .wr_data  (arr_wr_data),
        .last     (walk_last),
        .poll_bit (poll_bit)
    );

    pe_poll_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .busy      (busy),
        .rd_strobe (rd_strobe),
        .poll_bit  (poll_bit),
        .arr_byte  (arr_rd_data),
        .data_out  (data_out)
    );
endmodule

// File: rtl/pe_status_gen_chk.sv
// Protocol checker for pe_status_gen, attached by bind below.
module pe_status_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic [1:0] req_op,
    input logic       rd_strobe,
    input logic       arr_we,
    input logic       busy,
    input logic [7:0] data_out
);
    // R1: reset leaves the block idle with a cleared output.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !arr_we && data_out == 8'h00));

    // R13: array writes happen only inside the busy window.
    assert_write_in_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R3: an accepted request raises busy in the next cycle.
    assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_op != 2'b00 && !busy) |=> busy);

    // R11: a no-op request leaves the block idle.
    assert_noop_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_op == 2'b00 && !busy) |=> !busy);

    // R2: without a strobe the captured output does not move.
    assert_hold_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(data_out));

    // R9: a busy read access returns zero in the low six bits.
    assert_status_low_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_strobe) && busy) |=> (data_out[5:0] == 6'd0));
endmodule

bind pe_status_gen pe_status_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_op    (req_op),
    .rd_strobe (rd_strobe),
    .arr_we    (arr_we),
    .busy      (busy),
    .data_out  (data_out)
);

// File: tb/tb_pe_status_gen.sv
module tb_pe_status_gen;
    localparam int AW    = 8;
    localparam int SW    = 2;
    localparam int PC    = 12;
    localparam int EC    = 40;
    localparam int DEPTH = 1 << AW;
    localparam int SB    = 1 << (AW - SW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic [3:0]    sector_lock = 4'b0000;
    logic          rd_strobe = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [AW-1:0] arr_rd_addr;
    logic [7:0]    arr_rd_data;
    logic          arr_we;
    logic [AW-1:0] arr_wr_addr;
    logic [7:0]    arr_wr_data;
    logic          busy;
    logic [7:0]    data_out;

    logic [7:0] mem [0:DEPTH-1];
    logic [7:0] expv [0:DEPTH-1];
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int we_idle = 0;

    always #5 clk = ~clk;

    pe_status_gen #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .sector_lock(sector_lock), .rd_strobe(rd_strobe),
        .rd_addr(rd_addr), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
        .arr_we(arr_we), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
        .busy(busy), .data_out(data_out)
    );

    // Byte array model on the write port; combinational read port.
    always @(posedge clk) if (arr_we) mem[arr_wr_addr] <= arr_wr_data;
    assign arr_rd_data = mem[arr_rd_addr];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]  <= 8'((i * 7 + 3) & 8'hFF);
            expv[i] = 8'((i * 7 + 3) & 8'hFF);
        end
    end

    // Monitor for R13: writes outside the busy window.
    always @(negedge clk) if (rst_n && arr_we && !busy) we_idle++;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL R3 watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int expd);
        checks++;
        if (act != expd) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expd);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk); rd_addr = a; rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0; d = data_out;
    endtask

    task automatic sweep(input string tag);
        logic [7:0] d;
        for (int a = 0; a < DEPTH; a++) begin
            rd(AW'(a), d);
            chk(tag, d, expv[a]);
        end
    endtask

    // Issue one operation, read status every other busy cycle, count busy cycles.
    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                          input int exp_busy, input int intr_at, input logic [AW-1:0] ia,
                          input string tag);
        int   cnt;
        logic tog;
        logic pol;
        cnt = 0; tog = 1'b0;
        pol = (op == 2'b01) ? ~d[7] : 1'b0;
        @(negedge clk); req = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk); req = 1'b0; req_op = 2'b00;
        while (busy === 1'b1 && cnt < 5000) begin
            cnt++;
            if (cnt == intr_at) begin
                req = 1'b1; req_op = 2'b01; req_addr = ia; req_data = 8'h00;
            end else begin
                req = 1'b0; req_op = 2'b00;
            end
            rd_strobe = ~rd_strobe;
            @(negedge clk);
            if (rd_strobe) begin
                chk({tag, " R9 R10 status"}, data_out, {pol, tog, 6'b0});
                tog = ~tog;
            end
        end
        req = 1'b0; req_op = 2'b00; rd_strobe = 1'b0;
        chk({tag, " busy length"}, cnt, exp_busy);
    endtask

    task automatic m_prog(input logic [AW-1:0] a, input logic [7:0] d);
        if (!sector_lock[a[AW-1 -: SW]]) expv[a] = expv[a] & d;
    endtask

    task automatic m_erase_sect(input int s);
        if (!sector_lock[s]) for (int i = 0; i < SB; i++) expv[s * SB + i] = 8'hFF;
    endtask

    initial begin
        logic [7:0] d;
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 data_out", data_out, 8'h00);
        chk("R1 we", arr_we, 0);
        rst_n = 1'b1;

        // R2: idle read of every address.
        sweep("R2 idle sweep");

        // R2 R10: strobe held high counts as one access only.
        @(negedge clk); rd_addr = 8'h10; rd_strobe = 1'b1;
        @(negedge clk); rd_addr = 8'h20;
        @(negedge clk);
        @(negedge clk);
        chk("R2 held strobe", data_out, expv[8'h10]);
        rd_strobe = 1'b0;

        // R11: no-op request ignored.
        @(negedge clk); req = 1'b1; req_op = 2'b00;
        @(negedge clk); req = 1'b0;
        chk("R11 noop busy", busy, 0);

        // R3 R5 R9 R10: program with bit7 of data 0, then bit7 of data 1.
        run_op(2'b01, 8'h3C, 8'h0F, PC + 1, -1, 8'h00, "R3 prog a");
        m_prog(8'h3C, 8'h0F);
        rd(8'h3C, d); chk("R5 and result", d, expv[8'h3C]);
        run_op(2'b01, 8'h91, 8'h80, PC + 1, -1, 8'h00, "R3 prog b");
        m_prog(8'h91, 8'h80);
        rd(8'h91, d); chk("R5 and result b", d, expv[8'h91]);

        // R4 R6 R11: sector erase of sector 1 with a program request injected while busy.
        run_op(2'b10, 8'h47, 8'h00, EC + SB, 3, 8'hC5, "R4 R11 sect");
        m_erase_sect(1);
        sweep("R6 R11 sector sweep");

        // R8: writes into a locked sector do nothing but keep full duration.
        sector_lock = 4'b0001;
        run_op(2'b01, 8'h05, 8'h00, PC + 1, -1, 8'h00, "R8 prog locked");
        run_op(2'b10, 8'h10, 8'h00, EC + SB, -1, 8'h00, "R8 sect locked");
        sweep("R8 locked sweep");

        // R4 R7: full erase with sector 0 locked.
        run_op(2'b11, 8'h00, 8'h00, EC + DEPTH, -1, 8'h00, "R4 chip");
        for (int s = 0; s < 4; s++) m_erase_sect(s);
        sweep("R7 chip sweep");

        // R5: program into erased byte.
        run_op(2'b01, 8'hA3, 8'h5A, PC + 1, -1, 8'h00, "R3 prog c");
        m_prog(8'hA3, 8'h5A);
        rd(8'hA3, d); chk("R5 erased program", d, 8'h5A);

        // R12: reset mid-count abandons a sector erase of sector 0.
        sector_lock = 4'b0000;
        @(negedge clk); req = 1'b1; req_op = 2'b10; req_addr = 8'h20;
        @(negedge clk); req = 1'b0; req_op = 2'b00;
        repeat (5) @(negedge clk);
        chk("R12 busy during", busy, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 busy after", busy, 0);
        repeat (EC + SB + 4) @(negedge clk);
        sweep("R12 abort sweep");

        // R13: no write seen outside busy.
        chk("R13 idle writes", we_idle, 0);

        summary();
        $finish;
    end
endmodule